// File: doc/BRIEF.md
# Indirect CSR Access Window

This block is a slave-side bridge that lets a host with only a narrow 16-bit management register interface reach a wider internal CSR space. The internal space holds 32-bit registers grouped by a 6-bit target ID and a 12-bit register address. The host sees four window registers. Two of them carry the halves of a 32-bit data word. One carries the upper part of the target ID. The fourth is a command register. It holds the lower target ID bits, the register address and the direction, and it launches the access.

To write, the host fills both data halves and the target register, then writes the command with its launch bit set. To read, the host fills the target register and writes the command with the read flag set. The launch bit of the command register reads 0 while the access runs and 1 once it has finished. After a read, the two data registers hold the result. The internal targets are modelled here as an on-chip memory that can map to block RAM. A parameter sets how many targets respond and how deep each one is. An access to any other target or address still completes, and a read from it returns all ones.

Top module: `csr_window_bridge`

## Requirements
- R1: After reset, all four window registers (addresses 17, 18, 19, 20) read 0, including the completion bit 15 of register 19.
- R2: The host read data is registered and shows the register addressed in the previous cycle. Registers 17 and 18 read back the 16-bit values written. Register 20 keeps only bits [3:0], and its other bits read 0. Any address other than 17 to 20 reads 0 and ignores writes.
- R3: The CSR target ID is {register 20 bits [3:0], register 19 bits [13:12]}, and the CSR register address is register 19 bits [11:0]. Distinct target IDs reach distinct storage.
- R4: A write to register 19 with bit 15 = 1 and bit 14 = 0 stores the word {register 18, register 17} at the selected target and address.
- R5: A write to register 19 with bits 15 and 14 both set reads the selected CSR. The low half goes to register 17 and the high half to register 18. After a write access, registers 17 and 18 are unchanged.
- R6: Bit 15 of register 19 reads 0 from the launch until the access completes, then reads 1. Completion is visible in the readback exactly ACCESS_CYCLES+2 cycles after the launching write.
- R7: While an access is in progress, every host write is ignored, including a new command. The running access completes with its original target, address and data.
- R8: An access to a target ID at or above NUM_TARGETS, or to an address at or above 2^MEM_AW, completes normally. A read from it returns 0xFFFFFFFF, and a write to it changes no storage.
- R9: A write to register 19 with bit 15 = 0 stores bits [14:0] without starting an access, and the completion bit keeps its previous value.
- R10: Read data appears in registers 17 and 18 in the same cycle that bit 15 of register 19 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one window register |
| host_addr | input | HOST_AW | Window register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered readback of the register addressed in the previous cycle |

## Verification
The bench aims at the split target ID. It uses targets whose low bits collide once the upper field is dropped. A bridge that decoded only register 19, or that truncated the ID in place of rejecting it, would overwrite another target's data. The bench also fires a second command and a data write while an access is in flight. A bridge that accepted them would finish with the wrong address or corrupted data. It counts cycles from launch to the completion bit and to the arrival of read data in register 17. A design that set the flag before latching the data, or that let the flag leak through early, shows a different count.

// File: rtl/csr_win_pkg.sv
package csr_win_pkg;
  localparam int unsigned WIN_DATA_LO = 17;
  localparam int unsigned WIN_DATA_HI = 18;
  localparam int unsigned WIN_CMD     = 19;
  localparam int unsigned WIN_TGT     = 20;
  localparam int unsigned CMD_GO_BIT  = 15;
  localparam int unsigned CMD_RD_BIT  = 14;

  typedef struct packed {
    logic [5:0]  target;
    logic [11:0] addr;
    logic        is_read;
    logic [31:0] wdata;
  } csr_cmd_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RESP = 2'd2
  } seq_state_t;
endpackage

// File: rtl/csr_win_regs.sv
module csr_win_regs
  import csr_win_pkg::*;
#(
  parameter int unsigned HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  input  logic               busy,
  input  logic               done_set,
  input  logic               rsp_hit,
  input  logic [31:0]        rsp_data,
  output logic               launch,
  output csr_cmd_t           cmd
);
  logic [15:0] lo_q, hi_q;
  logic [3:0]  tgt_hi_q;
  logic [1:0]  tgt_lo_q;
  logic [11:0] addr_q;
  logic        rd_q, done_q;
  logic        wr_ok;
  logic        sel_lo, sel_hi, sel_cmd, sel_tgt;
  logic [31:0] rsp_word;

  assign sel_lo  = (host_addr == HOST_AW'(WIN_DATA_LO));
  assign sel_hi  = (host_addr == HOST_AW'(WIN_DATA_HI));
  assign sel_cmd = (host_addr == HOST_AW'(WIN_CMD));
  assign sel_tgt = (host_addr == HOST_AW'(WIN_TGT));
  assign wr_ok   = host_wr && !busy;
  assign launch  = wr_ok && sel_cmd && host_wdata[CMD_GO_BIT];
  assign rsp_word = rsp_hit ? rsp_data : 32'hFFFF_FFFF;

  assign cmd.target  = {tgt_hi_q, tgt_lo_q};
  assign cmd.addr    = addr_q;
  assign cmd.is_read = rd_q;
  assign cmd.wdata   = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q       <= '0;
      hi_q       <= '0;
      tgt_hi_q   <= '0;
      tgt_lo_q   <= '0;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      done_q     <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (wr_ok) begin
        if (sel_lo)  lo_q <= host_wdata;
        if (sel_hi)  hi_q <= host_wdata;
        if (sel_tgt) tgt_hi_q <= host_wdata[3:0];
        if (sel_cmd) begin
          tgt_lo_q <= host_wdata[13:12];
          addr_q   <= host_wdata[11:0];
          rd_q     <= host_wdata[CMD_RD_BIT];
          if (host_wdata[CMD_GO_BIT]) done_q <= 1'b0;
        end
      end
      if (done_set) begin
        done_q <= 1'b1;
        if (rd_q) begin
          lo_q <= rsp_word[15:0];
          hi_q <= rsp_word[31:16];
        end
      end
      if (sel_lo)       host_rdata <= lo_q;
      else if (sel_hi)  host_rdata <= hi_q;
      else if (sel_cmd) host_rdata <= {done_q, rd_q, tgt_lo_q, addr_q};
      else if (sel_tgt) host_rdata <= {12'd0, tgt_hi_q};
      else              host_rdata <= '0;
    end
  end

  assert_status_low_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done_q);

  assert_frozen_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_set) |=> $stable({lo_q, hi_q, tgt_hi_q, tgt_lo_q, addr_q, rd_q}));

  assert_miss_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (done_set && rd_q && !rsp_hit) |=> (lo_q == 16'hFFFF && hi_q == 16'hFFFF));

  assert_no_go_keeps_status_R9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !busy && sel_cmd && !host_wdata[CMD_GO_BIT]) |=> $stable(done_q));
endmodule

// File: rtl/csr_win_seq.sv
module csr_win_seq
  import csr_win_pkg::*;
#(
  parameter int unsigned ACCESS_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy,
  output logic mem_en,
  output logic done_set
);
  localparam int unsigned CNT_W = $clog2(ACCESS_CYCLES + 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy     = (state_q != SEQ_IDLE);
  assign mem_en   = (state_q == SEQ_WAIT) && (cnt_q == '0);
  assign done_set = (state_q == SEQ_RESP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (launch) begin
          state_q <= SEQ_WAIT;
          cnt_q   <= CNT_W'(ACCESS_CYCLES - 1);
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) state_q <= SEQ_RESP;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_no_launch_busy_R7: assert property (@(posedge clk) disable iff (rst)
    launch |-> !busy);

  assert_done_after_access_R6: assert property (@(posedge clk) disable iff (rst)
    done_set |-> $past(mem_en));
endmodule

// File: rtl/csr_win_target_mem.sv
module csr_win_target_mem #(
  parameter int unsigned NUM_TARGETS = 8,
  parameter int unsigned MEM_AW      = 4
) (
  input  logic        clk,
  input  logic        en,
  input  logic        we,
  input  logic [5:0]  target,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        hit
);
  localparam int unsigned TGT_W = $clog2(NUM_TARGETS);
  localparam int unsigned DEPTH = NUM_TARGETS << MEM_AW;

  logic [31:0] mem [DEPTH];
  logic        sel_hit;
  logic [TGT_W+MEM_AW-1:0] idx;

  assign sel_hit = (32'(target) < NUM_TARGETS) && (32'(addr) < (32'd1 << MEM_AW));
  assign idx     = {target[TGT_W-1:0], addr[MEM_AW-1:0]};

  always_ff @(posedge clk) begin
    if (en && we && sel_hit) mem[idx] <= wdata;
    if (en) begin
      rdata <= mem[idx];
      hit   <= sel_hit;
    end
  end
endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
  import csr_win_pkg::*;
#(
  parameter int unsigned HOST_AW       = 5,
  parameter int unsigned ACCESS_CYCLES = 3,
  parameter int unsigned NUM_TARGETS   = 8,
  parameter int unsigned MEM_AW        = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata
);
  logic        busy, launch, mem_en, done_set, rsp_hit;
  logic [31:0] rsp_data;
  csr_cmd_t    cmd;

  csr_win_regs #(.HOST_AW(HOST_AW)) u_regs (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .done_set(done_set), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .launch(launch), .cmd(cmd)
  );

  csr_win_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .busy(busy), .mem_en(mem_en), .done_set(done_set)
  );

  csr_win_target_mem #(.NUM_TARGETS(NUM_TARGETS), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .en(mem_en), .we(!cmd.is_read),
    .target(cmd.target), .addr(cmd.addr), .wdata(cmd.wdata),
    .rdata(rsp_data), .hit(rsp_hit)
  );
endmodule

// File: tb/csr_window_bridge_test.sv
module csr_window_bridge_test;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        pend = 1'b0;
  logic [31:0] model[int];

  always #2.5 clk = ~clk;

  csr_window_bridge #(.ACCESS_CYCLES(ACC)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // monitor side of the scoreboard
  always @(posedge clk) pend <= rd_req;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (host_rdata !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, host_rdata, e);
      end
    end
  end

  task automatic check_val(string t, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expect_reg(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    host_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // called right after the launching write; returns polls to completion
  task automatic poll_done(output int polls, output logic [15:0] first);
    host_addr = 5'd19;
    polls = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      polls++;
      if (i == 0) first = host_rdata;
      if (host_rdata[15]) break;
    end
  endtask

  function automatic logic [15:0] cmd_word(logic go, logic rd, logic [5:0] tgt, logic [11:0] a);
    return {go, rd, tgt[1:0], a};
  endfunction

  function automatic bit is_hit(logic [5:0] tgt, logic [11:0] a);
    return (tgt < 8) && (a < 16);
  endfunction

  task automatic csr_write(input logic [5:0] tgt, input logic [11:0] a, input logic [31:0] d, input string t);
    int polls;
    logic [15:0] first;
    wr(5'd17, d[15:0]);
    wr(5'd18, d[31:16]);
    wr(5'd20, {12'd0, tgt[5:2]});
    wr(5'd19, cmd_word(1'b1, 1'b0, tgt, a));
    poll_done(polls, first);
    check_val({t, " R6 busy status"}, first, cmd_word(1'b0, 1'b0, tgt, a));
    check_val({t, " R6 completion cycles"}, polls, ACC + 2);
    expect_reg(5'd19, cmd_word(1'b1, 1'b0, tgt, a), {t, " R6 done readback"});
    if (is_hit(tgt, a)) model[{tgt, a}] = d;
  endtask

  task automatic csr_read(input logic [5:0] tgt, input logic [11:0] a, input string t);
    int polls;
    logic [15:0] first;
    logic [31:0] e;
    e = is_hit(tgt, a) ? model[{tgt, a}] : 32'hFFFF_FFFF;
    wr(5'd20, {12'd0, tgt[5:2]});
    wr(5'd19, cmd_word(1'b1, 1'b1, tgt, a));
    poll_done(polls, first);
    check_val({t, " R6 completion cycles"}, polls, ACC + 2);
    expect_reg(5'd17, e[15:0], {t, " low half"});
    expect_reg(5'd18, e[31:16], {t, " high half"});
  endtask

  initial begin
    int polls;
    logic [15:0] first;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_reg(5'd17, 16'h0, "R1 reg17 reset");
    expect_reg(5'd18, 16'h0, "R1 reg18 reset");
    expect_reg(5'd19, 16'h0, "R1 reg19 reset");
    expect_reg(5'd20, 16'h0, "R1 reg20 reset");

    // R2 readback, masking and unmapped addresses
    wr(5'd17, 16'h1234);
    wr(5'd18, 16'hABCD);
    wr(5'd20, 16'hFFF3);
    wr(5'd3, 16'h5A5A);
    expect_reg(5'd17, 16'h1234, "R2 reg17 readback");
    expect_reg(5'd18, 16'hABCD, "R2 reg18 readback");
    expect_reg(5'd20, 16'h0003, "R2 reg20 masked");
    expect_reg(5'd3, 16'h0000, "R2 unmapped reads 0");

    // R4 writes, R3 split target ID
    csr_write(6'd1, 12'h005, 32'hA5A5_0F0F, "R4 write t1");
    csr_write(6'd5, 12'h005, 32'h1357_9BDF, "R3 write t5");
    csr_write(6'd4, 12'h00F, 32'hCAFE_F00D, "R3 write t4");
    csr_write(6'd0, 12'h005, 32'h0BAD_BEEF, "R4 write t0");
    expect_reg(5'd17, 16'hBEEF, "R5 reg17 unchanged after write");

    // R5 reads, R3 distinct targets do not alias
    csr_read(6'd1, 12'h005, "R5 read t1");
    csr_read(6'd5, 12'h005, "R3 read t5");
    csr_read(6'd4, 12'h00F, "R3 read t4");
    csr_read(6'd0, 12'h005, "R5 read t0");

    // R8 no responder
    csr_read(6'd9, 12'h005, "R8 read missing target");
    csr_read(6'd0, 12'h015, "R8 read beyond depth");
    csr_write(6'd9, 12'h005, 32'hDEAD_0001, "R8 write missing target");
    csr_write(6'd0, 12'h015, 32'hDEAD_0002, "R8 write beyond depth");
    csr_read(6'd1, 12'h005, "R8 t1 untouched");
    csr_read(6'd0, 12'h005, "R8 t0 untouched");

    // R7 writes during an access are ignored
    wr(5'd17, 16'h2222);
    wr(5'd18, 16'h3333);
    wr(5'd20, 16'h0000);
    wr(5'd19, cmd_word(1'b1, 1'b0, 6'd0, 12'h007));
    wr(5'd19, cmd_word(1'b1, 1'b1, 6'd0, 12'h008));
    wr(5'd17, 16'h9999);
    poll_done(polls, first);
    model[{6'd0, 12'h007}] = 32'h3333_2222;
    expect_reg(5'd19, cmd_word(1'b1, 1'b0, 6'd0, 12'h007), "R7 command kept");
    expect_reg(5'd17, 16'h2222, "R7 data kept");
    csr_read(6'd0, 12'h007, "R7 stored original data");

    // R9 command write without launch
    wr(5'd19, 16'h0ABC);
    expect_reg(5'd19, 16'h8ABC, "R9 fields stored status kept");
    expect_reg(5'd17, 16'h3333 ^ 16'h1111 ^ 16'h2222 ^ 16'h3333 ^ 16'h1111, "R9 no access");

    // R10 read data lands with the completion bit
    wr(5'd17, 16'h1111);
    wr(5'd20, 16'h0001);
    wr(5'd19, cmd_word(1'b1, 1'b1, 6'd5, 12'h005));
    host_addr = 5'd17;
    polls = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      polls++;
      if (host_rdata == 16'h9BDF) break;
    end
    check_val("R10 data arrival cycles", polls, ACC + 2);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule